// File: doc/BRIEF.md
# Load Value Predictor with Confidence Classifier

This block guesses the data a load instruction will return, working only from the instruction's address. Dependent instructions can then proceed before the cache access completes. It holds two untagged tables. The first is a value table that remembers the last data each load slot returned. The second is a smaller confidence table of 2-bit saturating counters, which decides whether a guess is trustworthy enough to act on. Both tables are indexed by low bits of the instruction address, so unrelated instructions that share index bits share an entry.

The front end sends every fetched instruction address into the lookup stream, whether or not it is a load. One cycle later the block returns a predicted value and a predict flag. When the instruction reaches the tag-check stage, the pipeline sends a resolve beat. That beat carries the address, whether the instruction really was a load, the predict flag it received, the value it was given, and the value the cache actually returned. Confirmed loads train both tables. A wrong guess that was acted on raises a one-cycle flush request for all younger instructions. Flushing, refetch and the cache itself live outside the block.

Both streams are valid-only. The block accepts a lookup beat and a resolve beat in every cycle, so it never applies back-pressure and has no ready pins. A lookup beat yields exactly one result beat in the next cycle.

Top module: `load_value_predictor`

## Requirements
- R1: A lookup beat (`lk_valid` high) in cycle t gives `pr_valid` high in cycle t+1. In that cycle `pr_value` holds the value-table entry selected by `lk_pc[11:2]`. `pr_valid` is low in any cycle that follows a cycle without a lookup beat.
- R2: `pr_predict` is high in cycle t+1 exactly when the confidence counter selected by `lk_pc[9:2]` held 2 or 3 at the lookup in cycle t. `pr_predict` is always low while `pr_valid` is low.
- R3: A resolve beat with `rs_is_load` high compares `rs_pred_value` against `rs_load_value`. It increments the counter at `rs_pc[9:2]` on equality and decrements it otherwise. The counter saturates at 3 and at 0.
- R4: A resolve beat with `rs_is_load` high writes `rs_load_value` into the value-table entry at `rs_pc[11:2]`, whether the guess was right or wrong.
- R5: A resolve beat with `rs_is_load` low, or any cycle with `rs_valid` low, leaves both tables unchanged.
- R6: `flush_req` is high for one cycle, in the cycle after a resolve beat that has `rs_is_load` high, `rs_pred_flag` high and `rs_pred_value` different from `rs_load_value`. It is low in every other cycle. A mismatch on a load that carries `rs_pred_flag` low never flushes.
- R7: After reset every counter holds 1 (one step below the predict threshold), every value entry holds 0, and `pr_valid`, `pr_predict` and `flush_req` are low.
- R8: When a lookup and a resolve select the same entry in the same cycle, the lookup returns the contents from before the resolve, and the resolve's update is still applied.
- R9: The tables carry no tags. Addresses that agree in bits [11:2] share a value entry, and addresses that agree in bits [9:2] share a counter.
- R10: Lookup and resolve beats may arrive in every cycle, back to back, with no cycle lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup beat present |
| lk_pc | input | PC_W | Instruction address of the lookup |
| pr_valid | output | 1 | Prediction beat present |
| pr_value | output | DATA_W | Predicted load data |
| pr_predict | output | 1 | High when the prediction should be used |
| rs_valid | input | 1 | Resolve beat present |
| rs_pc | input | PC_W | Instruction address being resolved |
| rs_is_load | input | 1 | Instruction turned out to be a load |
| rs_pred_flag | input | 1 | Predict flag the instruction received at lookup |
| rs_pred_value | input | DATA_W | Value the instruction was given at lookup |
| rs_load_value | input | DATA_W | Value actually returned by the cache |
| flush_req | output | 1 | Request to squash all younger instructions |

## Verification
Observing counter saturation at both ends requires long runs of agreeing or disagreeing resolves on one slot, with no other traffic disturbing that counter. The bench therefore drives directed bursts at a single address, and it checks aliasing by repeating those bursts with addresses that differ only above bit 9 or above bit 11. The collision case needs a lookup and a resolve on the same entry in the same cycle, and this is forced explicitly as well. A long random phase over a small pool of addresses and a small pool of values then produces frequent matches, mismatches and collisions. A behavioural table model predicts every output in every cycle.

// File: rtl/lvp_pkg.sv
package lvp_pkg;

  typedef enum logic [1:0] {
    CONF_NEVER = 2'd0,
    CONF_DOUBT = 2'd1,
    CONF_LIKELY = 2'd2,
    CONF_SURE = 2'd3
  } conf_e;

  localparam conf_e CONF_RESET = CONF_DOUBT;

  function automatic conf_e conf_step(input conf_e cur, input logic agreed);
    conf_e nxt;
    nxt = cur;
    if (agreed) begin
      if (cur != CONF_SURE) nxt = conf_e'(cur + 2'd1);
    end else begin
      if (cur != CONF_NEVER) nxt = conf_e'(cur - 2'd1);
    end
    return nxt;
  endfunction

  function automatic logic conf_trusted(input conf_e cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/lvp_value_table.sv
module lvp_value_table #(
  parameter int unsigned ENTRIES = 1024,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] slots [ENTRIES];

  // registered read: a same-cycle write is seen only by later reads
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= slots[rd_idx];
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slots[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        slots[g] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/lvp_conf_table.sv
module lvp_conf_table
  import lvp_pkg::*;
#(
  parameter int unsigned ENTRIES = 256,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_trust,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_agreed
);

  conf_e ctr [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_trust <= 1'b0;
    end else if (rd_en) begin
      rd_trust <= conf_trusted(ctr[rd_idx]);
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ctr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctr[g] <= CONF_RESET;
      end else if (upd_en && (upd_idx == IDX_W'(g))) begin
        ctr[g] <= conf_step(ctr[g], upd_agreed);
      end
    end
  end

endmodule

// File: rtl/load_value_predictor.sv
module load_value_predictor #(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned VT_ENTRIES = 1024,
  parameter int unsigned CT_ENTRIES = 256,
  parameter int unsigned PC_LSB     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              pr_valid,
  output logic [DATA_W-1:0] pr_value,
  output logic              pr_predict,
  input  logic              rs_valid,
  input  logic [PC_W-1:0]   rs_pc,
  input  logic              rs_is_load,
  input  logic              rs_pred_flag,
  input  logic [DATA_W-1:0] rs_pred_value,
  input  logic [DATA_W-1:0] rs_load_value,
  output logic              flush_req
);

  localparam int unsigned VT_IDX_W = $clog2(VT_ENTRIES);
  localparam int unsigned CT_IDX_W = $clog2(CT_ENTRIES);

  logic [VT_IDX_W-1:0] lk_vt_idx, rs_vt_idx;
  logic [CT_IDX_W-1:0] lk_ct_idx, rs_ct_idx;
  logic                rs_train, rs_agreed, ct_trust;
  logic                unused_pc_bits;

  assign lk_vt_idx = lk_pc[PC_LSB +: VT_IDX_W];
  assign rs_vt_idx = rs_pc[PC_LSB +: VT_IDX_W];
  assign lk_ct_idx = lk_pc[PC_LSB +: CT_IDX_W];
  assign rs_ct_idx = rs_pc[PC_LSB +: CT_IDX_W];
  assign unused_pc_bits = ^{lk_pc, rs_pc};

  // only confirmed loads train state
  assign rs_train  = rs_valid && rs_is_load;
  assign rs_agreed = (rs_pred_value == rs_load_value);

  lvp_value_table #(
    .ENTRIES(VT_ENTRIES),
    .DATA_W (DATA_W)
  ) u_values (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (lk_valid),
    .rd_idx (lk_vt_idx),
    .rd_data(pr_value),
    .wr_en  (rs_train),
    .wr_idx (rs_vt_idx),
    .wr_data(rs_load_value)
  );

  lvp_conf_table #(
    .ENTRIES(CT_ENTRIES)
  ) u_conf (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (lk_valid),
    .rd_idx    (lk_ct_idx),
    .rd_trust  (ct_trust),
    .upd_en    (rs_train),
    .upd_idx   (rs_ct_idx),
    .upd_agreed(rs_agreed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr_valid  <= 1'b0;
      flush_req <= 1'b0;
    end else begin
      pr_valid  <= lk_valid;
      flush_req <= rs_train && rs_pred_flag && !rs_agreed;
    end
  end

  assign pr_predict = pr_valid && ct_trust;

endmodule

// File: rtl/lvp_checker.sv
module lvp_checker #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              pr_valid,
  input logic              pr_predict,
  input logic              rs_valid,
  input logic              rs_is_load,
  input logic              rs_pred_flag,
  input logic [DATA_W-1:0] rs_pred_value,
  input logic [DATA_W-1:0] rs_load_value,
  input logic              flush_req
);

  logic acted_miss;
  assign acted_miss = rs_valid && rs_is_load && rs_pred_flag
                      && (rs_pred_value != rs_load_value);

  assert_lookup_answered_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> pr_valid);

  assert_no_spurious_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !pr_valid);

  assert_predict_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pr_valid |-> !pr_predict);

  assert_flush_on_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acted_miss |=> flush_req);

  assert_no_stray_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !acted_miss |=> !flush_req);

endmodule

bind load_value_predictor lvp_checker #(.PC_W(PC_W), .DATA_W(DATA_W)) u_lvp_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_valid     (lk_valid),
  .pr_valid     (pr_valid),
  .pr_predict   (pr_predict),
  .rs_valid     (rs_valid),
  .rs_is_load   (rs_is_load),
  .rs_pred_flag (rs_pred_flag),
  .rs_pred_value(rs_pred_value),
  .rs_load_value(rs_load_value),
  .flush_req    (flush_req)
);

// File: tb/load_value_predictor_test.sv
module load_value_predictor_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        pr_valid;
  logic [31:0] pr_value;
  logic        pr_predict;
  logic        rs_valid = 1'b0;
  logic [31:0] rs_pc = '0;
  logic        rs_is_load = 1'b0;
  logic        rs_pred_flag = 1'b0;
  logic [31:0] rs_pred_value = '0;
  logic [31:0] rs_load_value = '0;
  logic        flush_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model
  int unsigned vals [1024];
  int          conf [256];
  bit          e_valid = 0, e_predict = 0, e_flush = 0;
  int unsigned e_value = 0;

  always #4 clk = ~clk;

  load_value_predictor uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pr_valid(pr_valid), .pr_value(pr_value), .pr_predict(pr_predict),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_is_load(rs_is_load),
    .rs_pred_flag(rs_pred_flag), .rs_pred_value(rs_pred_value),
    .rs_load_value(rs_load_value), .flush_req(flush_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    check("R1 pr_valid", int'(pr_valid), int'(e_valid));
    check("R2 pr_predict", int'(pr_predict), int'(e_predict));
    check("R6 flush_req", int'(flush_req), int'(e_flush));
    if (e_valid) check("R1 pr_value", int'(pr_value), int'(e_value));
  endtask

  // one clock: check previous results, drive new beats, advance model
  task automatic step(input bit lv, input int unsigned lpc,
                      input bit rv, input int unsigned rpc, input bit ld,
                      input bit pf, input int unsigned pv, input int unsigned av);
    @(negedge clk);
    compare();
    lk_valid = lv; lk_pc = lpc;
    rs_valid = rv; rs_pc = rpc; rs_is_load = ld;
    rs_pred_flag = pf; rs_pred_value = pv; rs_load_value = av;
    e_valid = lv;
    e_predict = lv && (conf[(lpc >> 2) & 255] >= 2);
    if (lv) e_value = vals[(lpc >> 2) & 1023];
    e_flush = rv && ld && pf && (pv != av);
    if (rv && ld) begin
      vals[(rpc >> 2) & 1023] = av;
      if (pv == av) begin
        if (conf[(rpc >> 2) & 255] < 3) conf[(rpc >> 2) & 255]++;
      end else begin
        if (conf[(rpc >> 2) & 255] > 0) conf[(rpc >> 2) & 255]--;
      end
    end
  endtask

  task automatic look(input int unsigned pc);
    step(1, pc, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic resolve(input int unsigned pc, input bit ld, input bit pf,
                         input int unsigned pv, input int unsigned av);
    step(0, 0, 1, pc, ld, pf, pv, av);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) vals[i] = 0;
    for (int i = 0; i < 256; i++) conf[i] = 1;
    repeat (3) @(negedge clk);
    // R7: outputs low while in reset
    compare();
    rst_n = 1'b1;

    // R7: fresh entries read value 0, counter 1 (no predict)
    look(32'h100);
    look(32'h0);

    // R4 R3: mismatch on unflagged load, no flush, counter to 0
    resolve(32'h40, 1, 0, 0, 32'h55);
    look(32'h40);
    // R3: climb to saturation at 3
    for (int i = 0; i < 5; i++) begin
      resolve(32'h40, 1, 0, 32'h55, 32'h55);
      look(32'h40);
    end
    // R6: flagged mismatches flush, counter falls through threshold to 0
    for (int i = 0; i < 5; i++) begin
      resolve(32'h40, 1, 1, 32'h55, 32'h60 + i);
      look(32'h40);
    end

    // R5: non-load resolve and idle cycles with load set change nothing
    resolve(32'h40, 0, 1, 1, 2);
    step(0, 0, 0, 32'h40, 1, 1, 7, 8);
    look(32'h40);

    // R9: bit 12 aliases value entry, bit 10 aliases only the counter
    for (int i = 0; i < 3; i++) resolve(32'h1088, 1, 0, 9, 9);
    look(32'h88);
    look(32'h488);
    look(32'h1088);
    resolve(32'h488, 1, 0, 3, 3);
    look(32'h88);
    look(32'h488);

    // R8: lookup and resolve on one entry in one cycle return old data
    step(1, 32'h88, 1, 32'h88, 1, 1, 1, 32'hABCD);
    look(32'h88);
    step(1, 32'h1088, 1, 32'h88, 1, 0, 32'hABCD, 32'hABCD);
    look(32'h88);

    // R10: back-to-back random traffic over a small address and value pool
    for (int i = 0; i < 4000; i++) begin
      int unsigned lp, rp;
      lp = ($urandom_range(0, 7) << 2) | (32'($urandom_range(0, 1)) << 10)
           | (32'($urandom_range(0, 1)) << 12);
      rp = ($urandom_range(0, 7) << 2) | (32'($urandom_range(0, 1)) << 10)
           | (32'($urandom_range(0, 1)) << 12);
      step($urandom_range(0, 3) != 0, lp, $urandom_range(0, 3) != 0, rp,
           $urandom_range(0, 2) != 0, 1'($urandom_range(0, 1)),
           $urandom_range(0, 2), $urandom_range(0, 2));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule